// File: doc/BRIEF.md
# Keyed Power, Reset and Clock-Request Control

This block holds the power-enable, software-reset and clock-request settings for a single peripheral behind a small register bus. Every control write has to carry an 8-bit unlock key in bits 31:24, and each register has its own key. A write with the wrong key changes nothing. No error is reported for it.

A keyed reset command drives a one-cycle reset pulse to the peripheral. The same command sets a sticky status flag. Software can read that flag later to learn that a reset took place, and it clears the flag with a separate keyed command. Reads are combinational from the address. The key byte is never stored, so it always reads back as zero.

Top module: `periph_ctl_guard`

## Requirements
- R1: After rst_ni is deasserted, pwr_en_o, periph_rst_o and clk_req_block_o are 0, and every readable register returns 0.
- R2: A write to offset 0x800 whose bits 31:24 equal 0x26 loads bit 0 into the power-enable state. That state drives pwr_en_o and reads back in bit 0 of offset 0x800.
- R3: A write whose key byte differs from the key of the addressed register leaves every field of that register unchanged. This includes plain read/write fields.
- R4: A write to offset 0x804 with key 0xB1 and bit 0 set drives periph_rst_o high for exactly the one cycle after the write edge. No other write raises periph_rst_o.
- R5: The sticky reset flag is set in the same cycle as the reset pulse. It reads back in bit 16 of offset 0x814.
- R6: A write to offset 0x804 with key 0xB1, bit 1 set and bit 0 clear clears the sticky flag.
- R7: When one keyed write to 0x804 sets both bit 0 and bit 1, the flag ends up set and the pulse is still issued.
- R8: A keyed write to 0x804 with bits 1:0 equal to 0 neither pulses the reset nor changes the sticky flag.
- R9: A write to offset 0x808 with key 0xA9 loads bit 8 into the clock-request block state. That state drives clk_req_block_o and reads back in bit 8 of offset 0x808. Other data bits of that write are not stored.
- R10: Reads return 0 in the key byte and in all unused bits. Offset 0x804 and every unmapped offset read as 0. Writes to unmapped offsets change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 12 | Byte offset of the access |
| wdata_i | input | 32 | Write data, with the unlock key in bits 31:24 |
| rdata_o | output | 32 | Read data, valid combinationally while a read strobe is present |
| pwr_en_o | output | 1 | Peripheral power enable |
| periph_rst_o | output | 1 | One-cycle reset pulse to the peripheral |
| clk_req_block_o | output | 1 | Clock-request block configuration bit |

## Verification
The assertions assume the bus inputs are known and stable around each rising edge, with a write counted only when req_i and we_i are both high. The bench drives every input on the falling edge and returns the strobe to idle after each access, so each write lasts exactly one cycle. Key sweeps pass through all 256 key values at each keyed offset, with data chosen so that an accepted write always changes the state. The reset register is exercised with every combination of its two command bits, including both at once.

// File: rtl/pcg_pkg.sv
package pcg_pkg;
  localparam int DATA_W   = 32;
  localparam int KEY_W    = 8;
  localparam int KEY_LSB  = 24;
  localparam int NUM_KREG = 3;

  // keyed register index
  localparam int IDX_PWR = 0;
  localparam int IDX_RST = 1;
  localparam int IDX_CLK = 2;

  localparam int OFS_PWR  = 'h800;
  localparam int OFS_RST  = 'h804;
  localparam int OFS_CLK  = 'h808;
  localparam int OFS_STAT = 'h814;

  localparam int BIT_PWR_EN  = 0;
  localparam int BIT_RST_GO  = 0;
  localparam int BIT_RST_CLR = 1;
  localparam int BIT_CLK_BLK = 8;
  localparam int BIT_STICKY  = 16;

  function automatic int kreg_ofs(input int idx);
    case (idx)
      IDX_PWR: return OFS_PWR;
      IDX_RST: return OFS_RST;
      default: return OFS_CLK;
    endcase
  endfunction

  function automatic logic [KEY_W-1:0] kreg_key(input int idx);
    case (idx)
      IDX_PWR: return 8'h26;
      IDX_RST: return 8'hB1;
      default: return 8'hA9;
    endcase
  endfunction
endpackage

// File: rtl/pcg_key_gate.sv
module pcg_key_gate #(
  parameter int                ADDR_W = 12,
  parameter int                KEY_W  = 8,
  parameter logic [ADDR_W-1:0] OFFSET = '0,
  parameter logic [KEY_W-1:0]  KEY    = '0
) (
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [KEY_W-1:0]  key_i,
  output logic              unlock_o
);
  always_comb unlock_o = req_i && we_i && (addr_i == OFFSET) && (key_i == KEY);
endmodule

// File: rtl/pcg_sticky.sv
module pcg_sticky (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    q_o <= 1'b0;
    else if (set_i) q_o <= 1'b1;  // set beats clear
    else if (clr_i) q_o <= 1'b0;
  end
endmodule

// File: rtl/pcg_rd_mux.sv
module pcg_rd_mux
  import pcg_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              pwr_en_i,
  input  logic              clk_blk_i,
  input  logic              sticky_i,
  output logic [DATA_W-1:0] rdata_o
);
  always_comb begin
    rdata_o = '0;
    if (rd_i) begin
      if (addr_i == ADDR_W'(OFS_PWR))  rdata_o[BIT_PWR_EN]  = pwr_en_i;
      if (addr_i == ADDR_W'(OFS_CLK))  rdata_o[BIT_CLK_BLK] = clk_blk_i;
      if (addr_i == ADDR_W'(OFS_STAT)) rdata_o[BIT_STICKY]  = sticky_i;
    end
  end
endmodule

// File: rtl/periph_ctl_guard.sv
module periph_ctl_guard
  import pcg_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              pwr_en_o,
  output logic              periph_rst_o,
  output logic              clk_req_block_o
);
  logic [NUM_KREG-1:0] unlock;
  logic pwr_en_q, rst_pulse_q, clk_blk_q, sticky_q;
  logic rst_go, rst_clr;
  logic unused_wdata;

  for (genvar g = 0; g < NUM_KREG; g++) begin : g_kreg
    pcg_key_gate #(
      .ADDR_W (ADDR_W),
      .KEY_W  (KEY_W),
      .OFFSET (ADDR_W'(kreg_ofs(g))),
      .KEY    (kreg_key(g))
    ) i_gate (
      .req_i    (req_i),
      .we_i     (we_i),
      .addr_i   (addr_i),
      .key_i    (wdata_i[KEY_LSB +: KEY_W]),
      .unlock_o (unlock[g])
    );
  end

  assign rst_go  = unlock[IDX_RST] && wdata_i[BIT_RST_GO];
  assign rst_clr = unlock[IDX_RST] && wdata_i[BIT_RST_CLR];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pwr_en_q    <= 1'b0;
      rst_pulse_q <= 1'b0;
      clk_blk_q   <= 1'b0;
    end else begin
      if (unlock[IDX_PWR]) pwr_en_q  <= wdata_i[BIT_PWR_EN];
      if (unlock[IDX_CLK]) clk_blk_q <= wdata_i[BIT_CLK_BLK];
      rst_pulse_q <= rst_go;
    end
  end

  pcg_sticky i_sticky (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (rst_go),
    .clr_i  (rst_clr),
    .q_o    (sticky_q)
  );

  pcg_rd_mux #(.ADDR_W(ADDR_W)) i_rd (
    .rd_i      (req_i && !we_i),
    .addr_i    (addr_i),
    .pwr_en_i  (pwr_en_q),
    .clk_blk_i (clk_blk_q),
    .sticky_i  (sticky_q),
    .rdata_o   (rdata_o)
  );

  assign pwr_en_o        = pwr_en_q;
  assign periph_rst_o    = rst_pulse_q;
  assign clk_req_block_o = clk_blk_q;

  assign unused_wdata = ^{wdata_i[KEY_LSB-1:BIT_CLK_BLK+1], wdata_i[BIT_CLK_BLK-1:BIT_RST_CLR+1]};
endmodule

// File: rtl/periph_ctl_guard_chk.sv
module periph_ctl_guard_chk
  import pcg_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic              pwr_en_o,
  input logic              periph_rst_o,
  input logic              clk_req_block_o,
  input logic              sticky_i
);
  logic wr, pwr_ok, rst_ok, clk_ok;
  assign wr     = req_i && we_i;
  assign pwr_ok = wr && addr_i == ADDR_W'(OFS_PWR) && wdata_i[KEY_LSB +: KEY_W] == 8'h26;
  assign rst_ok = wr && addr_i == ADDR_W'(OFS_RST) && wdata_i[KEY_LSB +: KEY_W] == 8'hB1;
  assign clk_ok = wr && addr_i == ADDR_W'(OFS_CLK) && wdata_i[KEY_LSB +: KEY_W] == 8'hA9;

  AST_PWR_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwr_ok |=> $stable(pwr_en_o)); // R3
  AST_PWR_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwr_ok |=> pwr_en_o == $past(wdata_i[0])); // R2
  AST_CLK_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clk_ok |=> $stable(clk_req_block_o)); // R9
  AST_PULSE_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    periph_rst_o |=> !periph_rst_o); // R4
  AST_NO_STRAY_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rst_ok && wdata_i[0]) |=> !periph_rst_o); // R8
  AST_STICKY_WITH_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    periph_rst_o |-> sticky_i); // R5
  AST_STICKY_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rst_ok && wdata_i[1:0] == 2'b10) |=> !sticky_i); // R6
  AST_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rst_ok && wdata_i[1:0] == 2'b11) |=> sticky_i && periph_rst_o); // R7
endmodule

bind periph_ctl_guard periph_ctl_guard_chk #(.ADDR_W(ADDR_W)) i_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .req_i           (req_i),
  .we_i            (we_i),
  .addr_i          (addr_i),
  .wdata_i         (wdata_i),
  .pwr_en_o        (pwr_en_o),
  .periph_rst_o    (periph_rst_o),
  .clk_req_block_o (clk_req_block_o),
  .sticky_i        (sticky_q)
);

// File: tb/test_periph_ctl_guard.sv
module test_periph_ctl_guard;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        pwr_en, prst, clk_blk;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  periph_ctl_guard i_periph_ctl_guard (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .pwr_en_o(pwr_en),
    .periph_rst_o(prst), .clk_req_block_o(clk_blk)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // drive on falling edge, return after the next falling edge
  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    req = 1'b1; we = 1'b0; addr = a;
    #1 d = rdata;
    req = 1'b0;
  endtask

  initial begin
    logic [31:0] r;
    logic exp_pwr, exp_clk, exp_stk, exp_p;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 pwr", {31'b0, pwr_en}, 0);
    chk("R1 rst", {31'b0, prst}, 0);
    chk("R1 clk", {31'b0, clk_blk}, 0);
    rd(12'h800, r); chk("R1 rd800", r, 0);
    rd(12'h808, r); chk("R1 rd808", r, 0);
    rd(12'h814, r); chk("R1 rd814", r, 0);

    // R2/R3 power-enable key sweep, data always inverts current state
    exp_pwr = 1'b0;
    for (int k = 0; k < 256; k++) begin
      wr(12'h800, {k[7:0], 23'h7FFFFF, ~exp_pwr});
      if (k == 'h26) exp_pwr = ~exp_pwr;
      chk(k == 'h26 ? "R2 pwr" : "R3 pwr", {31'b0, pwr_en}, {31'b0, exp_pwr});
      rd(12'h800, r); chk("R2 R10 rd800", r, {31'b0, exp_pwr});
      chk("R4 no pulse from pwr", {31'b0, prst}, 0);
    end

    // R9/R3 clock-request sweep
    exp_clk = 1'b0;
    for (int k = 0; k < 256; k++) begin
      wr(12'h808, {k[7:0], 15'h7FFF, ~exp_clk, 8'hFF});
      if (k == 'hA9) exp_clk = ~exp_clk;
      chk(k == 'hA9 ? "R9 clk" : "R3 clk", {31'b0, clk_blk}, {31'b0, exp_clk});
      rd(12'h808, r); chk("R9 R10 rd808", r, {23'b0, exp_clk, 8'b0});
    end

    // R4/R5 reset-assert sweep
    exp_stk = 1'b0;
    for (int k = 0; k < 256; k++) begin
      wr(12'h804, {k[7:0], 22'h0, 2'b01});
      exp_p = (k == 'hB1);
      if (exp_p) exp_stk = 1'b1;
      chk(exp_p ? "R4 pulse" : "R3 no pulse", {31'b0, prst}, {31'b0, exp_p});
      rd(12'h814, r); chk("R5 sticky", r, {15'b0, exp_stk, 16'b0});
      @(negedge clk);
      chk("R4 single cycle", {31'b0, prst}, 0);
    end

    // R6/R3 sticky-clear sweep: key order puts wrong keys first
    for (int k = 0; k < 256; k++) begin
      wr(12'h804, {k[7:0], 22'h0, 2'b10});
      if (k == 'hB1) exp_stk = 1'b0;
      rd(12'h814, r); chk(k == 'hB1 ? "R6 clear" : "R3 clear", r, {15'b0, exp_stk, 16'b0});
      chk("R6 no pulse", {31'b0, prst}, 0);
    end

    // R8 zero command with key, flag clear then set
    wr(12'h804, {8'hB1, 24'h0});
    chk("R8 no pulse", {31'b0, prst}, 0);
    rd(12'h814, r); chk("R8 flag stays 0", r, 0);
    wr(12'h804, {8'hB1, 24'h1});
    @(negedge clk);
    wr(12'h804, {8'hB1, 24'h0});
    chk("R8 no pulse 2", {31'b0, prst}, 0);
    rd(12'h814, r); chk("R8 flag stays 1", r, 32'h0001_0000);

    // R7 set and clear together, from a cleared flag
    wr(12'h804, {8'hB1, 24'h2});
    rd(12'h814, r); chk("R7 pre clear", r, 0);
    wr(12'h804, {8'hB1, 24'h3});
    chk("R7 pulse", {31'b0, prst}, 1);
    rd(12'h814, r); chk("R7 set wins", r, 32'h0001_0000);
    @(negedge clk);

    // R10 reads of write-only and unmapped offsets, writes to unmapped offsets
    rd(12'h804, r); chk("R10 rd804", r, 0);
    rd(12'h80C, r); chk("R10 rd80C", r, 0);
    rd(12'h810, r); chk("R10 rd810", r, 0);
    rd(12'h000, r); chk("R10 rd000", r, 0);
    rd(12'hFFC, r); chk("R10 rdFFC", r, 0);
    foreach (r[i]) if (0) r[i] = 1'b0;
    for (int k = 0; k < 256; k += 5) begin
      wr(12'h80C, {k[7:0], 24'hFFFFFF});
      wr(12'h900, {k[7:0], 24'hFFFFFF});
    end
    chk("R10 unmapped pwr", {31'b0, pwr_en}, {31'b0, exp_pwr});
    chk("R10 unmapped clk", {31'b0, clk_blk}, {31'b0, exp_clk});
    rd(12'h814, r); chk("R10 unmapped sticky", r, 32'h0001_0000);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule